// File: doc/BRIEF.md
# 20-bit Indexed Effective-Address Generator

This block forms the effective address of an indexed operand on a processor with a 20-bit address space. The register operand supplies the base and the immediate field supplies a signed offset. A two-bit class select picks one of three rules. The first is plain indexing with a 16-bit offset. The second is address-instruction indexing with a 16-bit offset. The third is extended indexing with a full 20-bit offset.

The address-instruction rule has an irregular corner that the block reproduces exactly. When the base lies below 64K, only its low 16 bits are used, and they are sign-extended to 20 bits before the sign-extended offset is added. As a result, a sum that overflows wraps inside the lowest 64K, while a sum that underflows wraps at the top of the 1M space. Plain indexing with a base below 64K keeps the result inside 64K. Extended indexing is an ordinary 20-bit modular add.

A request is captured in an input register when its strobe is high. The result leaves an output register one cycle later, together with a valid pulse and a flag that is high when the address lies in the lowest 64K.

Top module: `idx_addr_gen`

## Requirements
- R1: Class code 01 (address instruction) with base bits 19:16 all zero gives (sign-extend base[15:0] to 20 bits) + (sign-extend offset[15:0]) mod 2^20. Offset 0xA4B6 with base 0x00006 gives 0xFA4BC. Offset 0x0006 with base 0x0FFFE gives 0x00004. Offset 0 with base 0x08000 gives 0xF8000.
- R2: Class code 01 with base at or above 0x10000 gives base + (sign-extend offset[15:0]) mod 2^20. Offset 0x0006 with base 0x1A4B6 gives 0x1A4BC, and offset 0x0006 with base 0xFFFFE gives 0x00004.
- R3: Class code 00 (plain) with base bits 19:16 all zero gives {4'b0, (base[15:0] + offset[15:0]) mod 2^16}.
- R4: Class code 00 with base at or above 0x10000 gives base + (sign-extend offset[15:0]) mod 2^20.
- R5: Class code 10 (extended) gives base + offset (all 20 bits) mod 2^20, with no special case.
- R6: Class code 11 gives the same result as class code 10.
- R7: In class codes 00 and 01, offset bits 19:16 have no effect on the result.
- R8: low64k_o is 1 exactly when addr_o bits 19:16 are all zero.
- R9: A request sampled with in_vld high at clock edge k appears on addr_o and low64k_o after edge k+1, with out_vld high for that one cycle.
- R10: If in_vld was low at edge k, out_vld is low after edge k+1, and addr_o and low64k_o keep their values.
- R11: While rst_n is low at a clock edge (synchronous reset), out_vld becomes 0, addr_o becomes 0 and low64k_o becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Request strobe |
| base_i | input | 20 | Base register value |
| ofs_i | input | 20 | Signed offset (16-bit classes use bits 15:0) |
| cls_i | input | 2 | Class: 00 plain, 01 address instruction, 10/11 extended |
| out_vld | output | 1 | Result valid pulse |
| addr_o | output | 20 | Effective address |
| low64k_o | output | 1 | Result lies below 0x10000 |

## Verification
Two things can happen in the same cycle: the output stage presents one result while the input stage captures the next request. The bench provokes this with back-to-back strobes whose classes and wrap directions alternate, and checks that every result matches its own request. An idle cycle with unrelated values on the inputs follows each such run, and the bench checks that the outputs hold while out_vld falls. A behavioural reference model, written with integer arithmetic, is stepped on every clock and compared each cycle.

// File: rtl/idxag_pkg.sv
// Package idxag_pkg
// Holds the shared widths and the encoding of the addressing class.
// Assumes the class codes are decoded upstream into this 2-bit field.
package idxag_pkg;
    localparam int ADDR_W = 20;
    localparam int OFS_W  = 16;

    typedef enum logic [1:0] {
        CLS_PLAIN = 2'b00,
        CLS_ADDR  = 2'b01,
        CLS_EXT   = 2'b10,
        CLS_RSV   = 2'b11
    } idx_cls_e;
endpackage

// File: rtl/idxag_in_stage.sv
// Module idxag_in_stage
// Registers one indexing request when its strobe is high.
// Assumes a synchronous active-low reset. The captured fields are held
// while no request arrives.
module idxag_in_stage #(
    parameter int AW = idxag_pkg::ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic [AW-1:0]        base_i,
    input  logic [AW-1:0]        ofs_i,
    input  idxag_pkg::idx_cls_e  cls_i,
    output logic                 vld_q,
    output logic [AW-1:0]        base_q,
    output logic [AW-1:0]        ofs_q,
    output idxag_pkg::idx_cls_e  cls_q
);
    // Capture request fields on a strobe; track the strobe every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            base_q <= '0;
            ofs_q  <= '0;
            cls_q  <= idxag_pkg::CLS_PLAIN;
        end else begin
            vld_q <= in_vld;
            if (in_vld) begin
                base_q <= base_i;
                ofs_q  <= ofs_i;
                cls_q  <= cls_i;
            end
        end
    end

    // R9: a sampled strobe reaches the stage valid one edge later.
    p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> vld_q);

    // R9: a captured base equals the value presented with the strobe.
    p_base_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (base_q == $past(base_i)));
endmodule

// File: rtl/idxag_calc.sv
// Module idxag_calc
// Purely combinational address arithmetic for the three indexing classes.
// Assumes SW < AW. The short classes use only the low SW offset bits.
// An unlisted class code falls back to the extended rule.
module idxag_calc #(
    parameter int AW = idxag_pkg::ADDR_W,
    parameter int SW = idxag_pkg::OFS_W
) (
    input  logic [AW-1:0]        base,
    input  logic [AW-1:0]        ofs,
    input  idxag_pkg::idx_cls_e  cls,
    output logic [AW-1:0]        addr
);
    localparam int HW = AW - SW;

    logic           base_low;
    logic [AW-1:0]  ofs_sx;
    logic [AW-1:0]  base_sx;
    logic [SW-1:0]  short_sum;
    logic [AW-1:0]  sum_short_full;
    logic [AW-1:0]  sum_addr_low;
    logic [AW-1:0]  sum_ext;

    // Build the extended operands and the candidate sums.
    always_comb begin
        base_low       = (base[AW-1:SW] == '0);
        ofs_sx         = {{HW{ofs[SW-1]}}, ofs[SW-1:0]};
        base_sx        = {{HW{base[SW-1]}}, base[SW-1:0]};
        short_sum      = base[SW-1:0] + ofs[SW-1:0];
        sum_short_full = base + ofs_sx;
        sum_addr_low   = base_sx + ofs_sx;
        sum_ext        = base + ofs;
    end

    // Choose the sum that the class and the base range call for.
    always_comb begin
        unique case (cls)
            idxag_pkg::CLS_PLAIN:
                addr = base_low ? {{HW{1'b0}}, short_sum} : sum_short_full;
            idxag_pkg::CLS_ADDR:
                addr = base_low ? sum_addr_low : sum_short_full;
            default:
                addr = sum_ext;
        endcase
    end

    // R3: a plain request with a low base never leaves the lowest window.
    always_comb begin
        if (cls == idxag_pkg::CLS_PLAIN && base[AW-1:SW] == '0) begin
            p_plain_trunc_r3: assert (addr[AW-1:SW] == '0);
        end
    end
endmodule

// File: rtl/idxag_out_stage.sv
// Module idxag_out_stage
// Registers the computed address, derives the low-window flag and
// drives the valid pulse. Holds its outputs when no result arrives.
// Assumes a synchronous active-low reset.
module idxag_out_stage #(
    parameter int AW = idxag_pkg::ADDR_W,
    parameter int SW = idxag_pkg::OFS_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           vld_q,
    input  logic [AW-1:0]  addr_d,
    output logic           out_vld,
    output logic [AW-1:0]  addr_o,
    output logic           low64k_o
);
    // Load a fresh result on a valid request, otherwise hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            addr_o   <= '0;
            low64k_o <= 1'b1;
        end else begin
            out_vld <= vld_q;
            if (vld_q) begin
                addr_o   <= addr_d;
                low64k_o <= (addr_d[AW-1:SW] == '0);
            end
        end
    end

    // R8: the flag agrees with the presented address.
    p_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        low64k_o == (addr_o[AW-1:SW] == '0));

    // R9: a captured request yields a valid pulse one edge later.
    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |=> out_vld);

    // R10: without a request the outputs hold and the pulse drops.
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_q |=> (!out_vld && $stable(addr_o) && $stable(low64k_o)));
endmodule

// File: rtl/idx_addr_gen.sv
// Module idx_addr_gen
// Top level of the indexed address generator: an input register, the
// class-dependent address arithmetic and an output register.
// Assumes a synchronous active-low reset and a class field with codes
// 00 plain, 01 address instruction, 10/11 extended.
module idx_addr_gen #(
    parameter int AW = idxag_pkg::ADDR_W,
    parameter int SW = idxag_pkg::OFS_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_vld,
    input  logic [AW-1:0]  base_i,
    input  logic [AW-1:0]  ofs_i,
    input  logic [1:0]     cls_i,
    output logic           out_vld,
    output logic [AW-1:0]  addr_o,
    output logic           low64k_o
);
    logic                 vld_q;
    logic [AW-1:0]        base_q;
    logic [AW-1:0]        ofs_q;
    idxag_pkg::idx_cls_e  cls_q;
    idxag_pkg::idx_cls_e  cls_in;
    logic [AW-1:0]        addr_d;

    // Interpret the raw class bits as the shared enumeration.
    always_comb begin
        cls_in = idxag_pkg::idx_cls_e'(cls_i);
    end

    idxag_in_stage #(.AW(AW)) i_in_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vld (in_vld),
        .base_i (base_i),
        .ofs_i  (ofs_i),
        .cls_i  (cls_in),
        .vld_q  (vld_q),
        .base_q (base_q),
        .ofs_q  (ofs_q),
        .cls_q  (cls_q)
    );

    idxag_calc #(.AW(AW), .SW(SW)) i_calc (
        .base (base_q),
        .ofs  (ofs_q),
        .cls  (cls_q),
        .addr (addr_d)
    );

    idxag_out_stage #(.AW(AW), .SW(SW)) i_out_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld_q    (vld_q),
        .addr_d   (addr_d),
        .out_vld  (out_vld),
        .addr_o   (addr_o),
        .low64k_o (low64k_o)
    );

    // R11: a reset edge clears the valid pulse.
    p_reset_r11: assert property (@(posedge clk)
        !rst_n |=> !out_vld);
endmodule

// File: tb/test_idx_addr_gen.sv
// Bench for idx_addr_gen: a behavioural model is stepped every clock
// and compared with the ports one time unit after each rising edge.
module test_idx_addr_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [19:0] base_i = '0;
    logic [19:0] ofs_i = '0;
    logic [1:0]  cls_i = '0;
    logic        out_vld;
    logic [19:0] addr_o;
    logic        low64k_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Model state: the stage-1 request and the presented output.
    bit          m1_vld = 1'b0;
    logic [19:0] m1_addr = '0;
    string       m1_tag = "R11";
    bit          mo_vld = 1'b0;
    logic [19:0] mo_addr = '0;
    string       mo_tag = "R11";

    idx_addr_gen i_idx_addr_gen (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .base_i(base_i),
        .ofs_i(ofs_i), .cls_i(cls_i), .out_vld(out_vld),
        .addr_o(addr_o), .low64k_o(low64k_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Integer reference of the indexing rules.
    function automatic logic [19:0] ref_addr(input int b, input int o, input int c);
        int s16;
        int bb;
        s16 = o & 32'hFFFF;
        if (s16 >= 32768) s16 = s16 - 65536;
        if (c >= 2) return 20'((b + o) & 32'hFFFFF);
        if (b < 32'h10000) begin
            if (c == 0) return 20'((b + s16) & 32'hFFFF);
            bb = (b >= 32768) ? b - 65536 : b;
            return 20'((bb + s16) & 32'hFFFFF);
        end
        return 20'((b + s16) & 32'hFFFFF);
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic exp_low;
        exp_low = (mo_addr[19:16] == 4'h0);
        check(mo_vld ? "R9" : "R10", "out_vld", int'(out_vld), int'(mo_vld));
        check(mo_tag, "addr_o", int'(addr_o), int'(mo_addr));
        check("R8", "low64k_o", int'(low64k_o), int'(exp_low));
    endtask

    // One clock: drive at the falling edge, advance the model, then compare.
    task automatic step(input bit v, input logic [19:0] b, input logic [19:0] o,
                        input logic [1:0] c, input string tag);
        @(negedge clk);
        in_vld = v; base_i = b; ofs_i = o; cls_i = c;
        @(posedge clk);
        #1;
        mo_vld = m1_vld;
        if (m1_vld) begin
            mo_addr = m1_addr;
            mo_tag  = m1_tag;
        end else begin
            mo_tag = "R10";
        end
        m1_vld = v;
        if (v) begin
            m1_addr = ref_addr(int'(b), int'(o), int'(c));
            m1_tag  = tag;
        end
        compare_all();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11: reset values
        check("R11", "out_vld", int'(out_vld), 0);
        check("R11", "addr_o", int'(addr_o), 0);
        check("R11", "low64k_o", int'(low64k_o), 1);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: address class, base below 64K (1M underflow, 64K overflow)
        step(1, 20'h00006, 20'h0A4B6, 2'b01, "R1");
        step(1, 20'h0FFFE, 20'h00006, 2'b01, "R1");
        step(1, 20'h08000, 20'h00000, 2'b01, "R1");
        step(0, 20'h12345, 20'h54321, 2'b10, "R10");
        // R2: address class, base at or above 64K
        step(1, 20'h1A4B6, 20'h00006, 2'b01, "R2");
        step(1, 20'hFFFFE, 20'h00006, 2'b01, "R2");
        step(1, 20'h20000, 20'h0FFFF, 2'b01, "R2");
        step(0, 20'hABCDE, 20'h0FFFF, 2'b11, "R10");
        step(0, 20'h00000, 20'h00000, 2'b00, "R10");
        // R3: plain class, base below 64K truncates to 16 bits
        step(1, 20'h0FFFE, 20'h00006, 2'b00, "R3");
        step(1, 20'h00006, 20'h0A4B6, 2'b00, "R3");
        // R4: plain class, base at or above 64K
        step(1, 20'h1A4B6, 20'h0FFFA, 2'b00, "R4");
        step(0, 20'h0, 20'h0, 2'b00, "R10");
        // R5: extended class, full 20-bit offset
        step(1, 20'h00006, 20'h0A4B6, 2'b10, "R5");
        step(1, 20'hFFFFE, 20'h00006, 2'b10, "R5");
        step(1, 20'h0FFFE, 20'h00006, 2'b10, "R5");
        step(1, 20'h00010, 20'hFFFF0, 2'b10, "R5");
        // R6: code 11 behaves as extended
        step(1, 20'h0FFFE, 20'h00006, 2'b11, "R6");
        step(1, 20'h00006, 20'h5A4B6, 2'b11, "R6");
        // R7: offset bits 19:16 ignored in the 16-bit classes
        step(1, 20'h00006, 20'hFA4B6, 2'b01, "R7");
        step(1, 20'h0FFFE, 20'h50006, 2'b00, "R7");
        step(1, 20'h1A4B6, 20'h30006, 2'b01, "R7");
        step(0, 20'hFFFFF, 20'hFFFFF, 2'b10, "R10");
        step(0, 20'h0, 20'h0, 2'b00, "R10");

        // R11: reset in mid-stream clears the outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R11", "out_vld after reset", int'(out_vld), 0);
        check("R11", "addr_o after reset", int'(addr_o), 0);
        check("R11", "low64k_o after reset", int'(low64k_o), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule